// File: doc/BRIEF.md
# Bandwidth-Throttled Request Acceptor

This block sits at the entry of a simple memory target and limits how fast requests may arrive. A requester offers a read or a write with a valid/ready handshake. Every legal request taken in holds the block off new traffic for a number of cycles, the request's byte count times a per-byte cycle cost given on an input. A request offered during that hold-off is turned away, and the block records that it owes the requester a retry. When the hold-off ends, the block clears the record and sends out a one-cycle retry pulse. The requester then knows it can offer the request again.

Accepted requests that expect an answer go out on a registered forward port toward the storage and response logic. Requests that expect no answer are taken in and produce no output. A command other than read or write sets a sticky error flag. If the byte count times the cost is zero, the block never holds off, so it can take a request on every cycle.

Top module: `bw_req_gate`

## Requirements
- R1: After reset, `req_ready` is 1 and `retry_pulse`, `fwd_valid` and `cmd_error` are 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1 at a rising edge. A legal request accepted with `req_size * cost_per_byte` = N > 0 makes `req_ready` 0 for exactly the N cycles that follow, after which it returns to 1.
- R3: When N = 0 the block does not hold off. `req_ready` stays 1, and a request can be accepted on every cycle.
- R4: While the hold-off is running, `req_ready` is 0. A request offered then is refused and is never forwarded.
- R5: If one or more requests were refused during a hold-off, `retry_pulse` is 1 for exactly one cycle: the first cycle in which `req_ready` is 1 again. If none were refused, there is no pulse.
- R6: `req_cmd` 2'b00 is a read and 2'b01 is a write. An accepted request with 2'b10 or 2'b11 sets `cmd_error` on the next cycle. The flag stays set until reset, and the request neither starts a hold-off nor is forwarded.
- R7: A legal request accepted with `req_need_rsp` = 1 gives `fwd_valid` = 1 for one cycle on the next cycle, with `fwd_addr`, `fwd_size` and `fwd_write` (1 for a write) taken from that request. With `req_need_rsp` = 0 there is no forward pulse.
- R8: `cost_per_byte` is sampled only at acceptance. Changing it during a hold-off does not change that hold-off's length. The counter covers the largest product, 64 bytes times the largest cost, without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cost_per_byte | input | COST_W | Hold-off cycles charged per request byte |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block will accept a request this cycle |
| req_addr | input | ADDR_W | Request address |
| req_cmd | input | 2 | 00 read, 01 write, other values illegal |
| req_size | input | SIZE_W | Request size in bytes, 0 to MAX_SIZE |
| req_need_rsp | input | 1 | Request expects a response |
| fwd_valid | output | 1 | Forwarded request strobe |
| fwd_addr | output | ADDR_W | Address of the forwarded request |
| fwd_size | output | SIZE_W | Size of the forwarded request |
| fwd_write | output | 1 | Forwarded request is a write |
| retry_pulse | output | 1 | One-cycle retry notice after a refused offer |
| cmd_error | output | 1 | Sticky illegal-command flag |

## Verification
A wrong hold-off count shows at `req_ready` on the cycle where the count should have reached zero. It is too early or too late by the size of the error, so long products are needed to expose wrap-around in the counter. A lost or stuck retry record shows as a missing or extra `retry_pulse`, or a `req_ready` that stays low, on the first cycle after the hold-off. A wrong sampling time for the cost input shows only when that input moves during a hold-off, so the stimulus changes it on every cycle.

// File: rtl/bw_gate_pkg.sv
package bw_gate_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_RSV2  = 2'b10,
    CMD_RSV3  = 2'b11
  } gate_cmd_e;

  function automatic logic cmd_is_legal(input logic [1:0] c);
    return (c == CMD_READ) || (c == CMD_WRITE);
  endfunction
endpackage

// File: rtl/bw_dur_calc.sv
module bw_dur_calc #(
  parameter int SIZE_W = 7,
  parameter int COST_W = 4,
  localparam int DUR_W = SIZE_W + COST_W
) (
  input  logic [SIZE_W-1:0] size,
  input  logic [COST_W-1:0] cost,
  output logic [DUR_W-1:0]  dur
);
  // full-width product: SIZE_W+COST_W bits cannot wrap
  always_comb dur = DUR_W'(size) * DUR_W'(cost);
endmodule

// File: rtl/bw_busy_timer.sv
module bw_busy_timer #(
  parameter int DUR_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DUR_W-1:0] dur,
  input  logic             req_valid,
  output logic             ready,
  output logic             retry_pulse
);
  logic [DUR_W-1:0] cnt_q, cnt_d;
  logic pend_q, pend_d;
  logic busy, expire, refused;

  always_comb begin
    busy    = (cnt_q != '0);
    expire  = (cnt_q == DUR_W'(1));
    refused = req_valid && !ready;
    if (load && dur != '0)      cnt_d = dur;
    else if (busy)              cnt_d = cnt_q - DUR_W'(1);
    else                        cnt_d = cnt_q;
    pend_d = expire ? 1'b0 : (pend_q || refused);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      pend_q      <= 1'b0;
      ready       <= 1'b1;
      retry_pulse <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      pend_q      <= pend_d;
      ready       <= (cnt_d == '0) && !pend_d;
      retry_pulse <= expire && (pend_q || refused);
    end
  end

  // R2: a nonzero load drops ready on the next cycle
  p_load_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (load && dur != '0) |=> !ready);
  // R3: a zero-length load from idle keeps ready high
  p_zero_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (load && dur == '0 && !busy && !pend_q) |=> ready);
  // R4: an offer during hold-off leaves a retry obligation or a pulse
  p_refuse_owed_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> (pend_q || retry_pulse));
  // R5: retry is a single-cycle pulse, coincident with ready
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    retry_pulse |=> !retry_pulse);
  p_pulse_ready_r5: assert property (@(posedge clk) disable iff (rst)
    retry_pulse |-> ready);
endmodule

// File: rtl/bw_req_fwd.sv
module bw_req_fwd #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              legal,
  input  logic              need_rsp,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [SIZE_W-1:0] fwd_size,
  output logic              fwd_write,
  output logic              cmd_error
);
  logic take;
  always_comb take = accept && legal && need_rsp;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      cmd_error <= 1'b0;
    end else begin
      fwd_valid <= take;
      if (accept && !legal) cmd_error <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      fwd_addr  <= addr;
      fwd_size  <= size;
      fwd_write <= is_write;
    end
  end

  // R6: error flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_error |=> cmd_error);
  // R7: no-response requests produce no forward strobe
  p_no_rsp_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && !need_rsp) |=> !fwd_valid);
endmodule

// File: rtl/bw_req_gate.sv
module bw_req_gate #(
  parameter int ADDR_W   = 32,
  parameter int MAX_SIZE = 64,
  parameter int COST_W   = 4,
  localparam int SIZE_W  = $clog2(MAX_SIZE + 1),
  localparam int DUR_W   = SIZE_W + COST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COST_W-1:0] cost_per_byte,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_cmd,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_need_rsp,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [SIZE_W-1:0] fwd_size,
  output logic              fwd_write,
  output logic              retry_pulse,
  output logic              cmd_error
);
  import bw_gate_pkg::*;

  logic accept, legal, load;
  logic [DUR_W-1:0] dur;

  always_comb begin
    accept = req_valid && req_ready;
    legal  = cmd_is_legal(req_cmd);
    load   = accept && legal;
  end

  bw_dur_calc #(.SIZE_W(SIZE_W), .COST_W(COST_W)) u_dur (
    .size(req_size), .cost(cost_per_byte), .dur(dur)
  );

  bw_busy_timer #(.DUR_W(DUR_W)) u_timer (
    .clk(clk), .rst(rst), .load(load), .dur(dur), .req_valid(req_valid),
    .ready(req_ready), .retry_pulse(retry_pulse)
  );

  bw_req_fwd #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_fwd (
    .clk(clk), .rst(rst), .accept(accept), .legal(legal),
    .need_rsp(req_need_rsp), .is_write(req_cmd == CMD_WRITE),
    .addr(req_addr), .size(req_size),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_size(fwd_size),
    .fwd_write(fwd_write), .cmd_error(cmd_error)
  );

  // R4: refused offers are never forwarded
  p_refused_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> !fwd_valid);
  // R6: illegal commands start no hold-off
  p_illegal_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (accept && !legal) |=> req_ready);
endmodule

// File: tb/bw_req_gate_test.sv
module bw_req_gate_test;
  localparam int ADDR_W = 32;
  localparam int MAX_SIZE = 64;
  localparam int COST_W = 4;
  localparam int SIZE_W = $clog2(MAX_SIZE + 1);

  logic clk = 1'b0;
  logic rst;
  logic [COST_W-1:0] cost_per_byte;
  logic req_valid, req_ready, req_need_rsp;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0] req_cmd;
  logic [SIZE_W-1:0] req_size;
  logic fwd_valid, fwd_write, retry_pulse, cmd_error;
  logic [ADDR_W-1:0] fwd_addr;
  logic [SIZE_W-1:0] fwd_size;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model state
  int rem;
  bit pend_m, pulse_m, err_m, fv_m, fw_m;
  logic [ADDR_W-1:0] fa_m;
  int fs_m;
  int pulse_count, ready_low, ready_high;

  always #10 clk = ~clk;

  bw_req_gate #(.ADDR_W(ADDR_W), .MAX_SIZE(MAX_SIZE), .COST_W(COST_W)) uut (
    .clk(clk), .rst(rst), .cost_per_byte(cost_per_byte),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_size(req_size), .req_need_rsp(req_need_rsp),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_size(fwd_size),
    .fwd_write(fwd_write), .retry_pulse(retry_pulse), .cmd_error(cmd_error)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit ready_model();
    return (rem == 0) && !pend_m;
  endfunction

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0; req_cmd = 2'b00; req_size = '0;
    req_need_rsp = 1'b0; req_addr = '0; cost_per_byte = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    rem = 0; pend_m = 0; pulse_m = 0; err_m = 0; fv_m = 0;
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(retry_pulse == 1'b0, "R1", "retry after reset", retry_pulse, 0);
    chk(fwd_valid == 1'b0, "R1", "fwd_valid after reset", fwd_valid, 0);
    chk(cmd_error == 1'b0, "R1", "cmd_error after reset", cmd_error, 0);
  endtask

  // one clock cycle: drive at negedge, update model, check at next negedge
  task automatic cycle(input bit v, input logic [1:0] c, input int sz,
                       input bit need, input logic [ADDR_W-1:0] a,
                       input int cost);
    bit acc, legal, refused, expire;
    int dur;
    req_valid = v; req_cmd = c; req_size = SIZE_W'(sz);
    req_need_rsp = need; req_addr = a; cost_per_byte = COST_W'(cost);
    acc = v && ready_model();
    legal = (c == 2'b00) || (c == 2'b01);
    refused = v && !ready_model();
    expire = (rem == 1);
    dur = sz * cost;
    fv_m = acc && legal && need;
    if (fv_m) begin fa_m = a; fs_m = sz; fw_m = (c == 2'b01); end
    if (acc && !legal) err_m = 1;
    pulse_m = expire && (pend_m || refused);
    if (acc && legal && dur != 0) rem = dur;
    else if (rem > 0) rem--;
    pend_m = expire ? 1'b0 : (pend_m || refused);
    @(posedge clk);
    @(negedge clk);
    chk(req_ready == ready_model(), "R2", "req_ready", req_ready, ready_model());
    chk(retry_pulse == pulse_m, "R5", "retry_pulse", retry_pulse, pulse_m);
    chk(fwd_valid == fv_m, "R7", "fwd_valid", fwd_valid, fv_m);
    if (fv_m && fwd_valid) begin
      chk(fwd_addr == fa_m, "R7", "fwd_addr", fwd_addr, fa_m);
      chk(int'(fwd_size) == fs_m, "R7", "fwd_size", fwd_size, fs_m);
      chk(fwd_write == fw_m, "R7", "fwd_write", fwd_write, fw_m);
    end
    chk(cmd_error == err_m, "R6", "cmd_error", cmd_error, err_m);
    if (retry_pulse) pulse_count++;
    if (req_ready) ready_high++; else ready_low++;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();

    // R3: zero cost, back-to-back accepts
    ready_high = 0;
    for (int i = 0; i < 20; i++) cycle(1, 2'b00, 8, 1, ADDR_W'(i), 0);
    chk(ready_high == 20, "R3", "ready cycles at zero cost", ready_high, 20);

    // R2: size 4 cost 2 -> 8 cycles low, then R5 with no refusal: no pulse
    pulse_count = 0; ready_low = 0;
    cycle(1, 2'b01, 4, 0, 32'h100, 2);
    for (int i = 0; i < 10; i++) cycle(0, 2'b00, 0, 0, '0, 2);
    chk(ready_low == 8, "R2", "hold-off length", ready_low, 8);
    chk(pulse_count == 0, "R5", "pulse without refusal", pulse_count, 0);

    // R4/R5: refused offer during hold-off gives one pulse
    pulse_count = 0;
    cycle(1, 2'b00, 3, 1, 32'h200, 1);
    cycle(1, 2'b01, 5, 1, 32'h300, 1);
    for (int i = 0; i < 5; i++) cycle(0, 2'b00, 0, 0, '0, 1);
    chk(pulse_count == 1, "R5", "pulse after refusal", pulse_count, 1);

    // R8: largest product, cost changes during hold-off
    ready_low = 0;
    cycle(1, 2'b00, MAX_SIZE, 1, 32'hABC0, 15);
    for (int i = 0; i < 970; i++) cycle(0, 2'b00, 0, 0, '0, i % 16);
    chk(ready_low == 960, "R8", "max hold-off length", ready_low, 960);

    // random phase, legal commands, cost moving every cycle
    for (int i = 0; i < 4000; i++) begin
      cycle(($urandom % 2) == 1, 2'($urandom % 2), int'($urandom % (MAX_SIZE + 1)),
            ($urandom % 2) == 1, $urandom, int'($urandom % 4));
    end
    while (!ready_model()) cycle(0, 2'b00, 0, 0, '0, 0);

    // R6: illegal command sets sticky error, no hold-off, no forward
    cycle(1, 2'b10, 16, 1, 32'h400, 3);
    chk(req_ready == 1'b1, "R6", "no hold-off on illegal", req_ready, 1);
    chk(fwd_valid == 1'b0, "R6", "no forward on illegal", fwd_valid, 0);
    for (int i = 0; i < 4; i++) cycle(0, 2'b00, 0, 0, '0, 0);
    chk(cmd_error == 1'b1, "R6", "error sticky", cmd_error, 1);
    cycle(1, 2'b11, 2, 0, 32'h500, 0);

    do_reset();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule